// File: doc/BRIEF.md
# Programmable Latency Hit Pipeline

This block sits at the result end of a cascadable search engine. Each cycle it takes the operation type, the raw search-hit strobe from the search array and the raw memory-read acknowledge. After a fixed number of cycles it presents them as a hit flag, a valid flag and an acknowledge. That number is a base depth chosen by a table-size code, plus an extra delay of 0 to 7 cycles. A new operation may enter every cycle, and results leave in the order they entered.

The block also decides when this device drives shared lines. If this device holds the last-device flag, it supplies default values for the hit and valid flags whenever no search hit is being reported. If this device holds the last-on-bus flag, it parks the external memory bus at inactive defaults whenever this device is not driving it. It also always drives the memory output-enable line. Every output is registered.

Top module: `hit_latency_pipe`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, hit_o, valid_o, flag_oe_o, ack_o, bus_oe_o and oe_en_o are all 0.
- R2: With size code 2'b00 and extra code 0, an operation presented in cycle c has its result on the flag outputs in cycle c+4.
- R3: Size code 2'b01 gives a base latency of 5 cycles and 2'b10 gives 6. The reserved code 2'b11 also gives 6.
- R4: The extra code (0..7) adds its binary value in cycles to the base latency, for both the flag outputs and ack_o.
- R5: A search (op 2'b01) with hit_i=1 produces hit_o=1, valid_o=1 and flag_oe_o=1 after the latency.
- R6: A search with hit_i=0 produces hit_o=0, valid_o=1, flag_oe_o=1 when cfg_last_dev_i=1. When cfg_last_dev_i=0 it produces flag_oe_o=0 with hit_o=valid_o=0.
- R7: For a non-search result slot, a last device drives hit_o=0, valid_o=0, flag_oe_o=1. Any other device drives flag_oe_o=0.
- R8: ack_o is 1 exactly at the latency after a read (op 2'b10) with ack_i=1. ack_i has no effect during idle (2'b00), search or write (2'b11).
- R9: Operations presented on consecutive cycles, of mixed types, give their results on consecutive cycles in the same order.
- R10: When local_drive_i=1 in cycle c, in cycle c+1 sadr_o, ce_n_o, we_n_o and ale_n_o equal the cycle-c inputs and bus_oe_o=1.
- R11: When local_drive_i=0 and cfg_last_bus_i=1 in cycle c, in cycle c+1 sadr_o is all ones, ce_n_o=we_n_o=ale_n_o=1 and bus_oe_o=1. With both at 0, bus_oe_o=0.
- R12: In cycle c+1, oe_en_o equals cfg_last_bus_i OR local_drive_i of cycle c. oe_n_o equals oe_n_i when local_drive_i was 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_i | input | 2 | Table-size code selecting the base latency |
| cfg_extra_i | input | 3 | Extra latency in cycles |
| cfg_last_dev_i | input | 1 | Device is last in the depth cascade |
| cfg_last_bus_i | input | 1 | Device is last on its memory bus |
| op_i | input | 2 | Operation: 00 idle, 01 search, 10 read, 11 write |
| hit_i | input | 1 | Raw search hit for this cycle's operation |
| ack_i | input | 1 | Raw read acknowledge for this cycle's operation |
| local_drive_i | input | 1 | This device owns the memory bus this cycle |
| sadr_i | input | ADDR_W | Memory address to drive when owning the bus |
| ce_n_i | input | 1 | Chip enable (active low) to drive |
| we_n_i | input | 1 | Write enable (active low) to drive |
| ale_n_i | input | 1 | Address latch enable (active low) to drive |
| oe_n_i | input | 1 | Output enable (active low) to drive |
| hit_o | output | 1 | Delayed hit flag |
| valid_o | output | 1 | Delayed valid flag |
| flag_oe_o | output | 1 | Drive enable for hit_o and valid_o |
| ack_o | output | 1 | Delayed read acknowledge |
| sadr_o | output | ADDR_W | Memory address out |
| ce_n_o | output | 1 | Chip enable out |
| we_n_o | output | 1 | Write enable out |
| ale_n_o | output | 1 | Address latch enable out |
| bus_oe_o | output | 1 | Drive enable for address, ce, we and ale |
| oe_n_o | output | 1 | Output enable line value |
| oe_en_o | output | 1 | Drive enable for the output-enable line |

## Verification
The pipeline is first driven with an isolated search and then idle cycles, under each size code and each extra code. A result landing one cycle early or late shows up as a mismatch in a known cycle. Hits, misses and idle slots are repeated with the last-device flag both set and clear, to separate the device that answers from the one that stays silent. A dense stream of mixed searches, reads and writes, with ack_i raised on every type, distinguishes correct ordering and read-only acknowledge from a misplaced tap or an ack that leaks from other operations. The bus is exercised with ownership toggling under both values of the last-on-bus flag.

// File: rtl/hlp_pkg.sv
package hlp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_SEARCH = 2'b01,
    OP_READ   = 2'b10,
    OP_WRITE  = 2'b11
  } op_e;

  typedef struct packed {
    logic srch;
    logic hit;
    logic ack;
  } slot_t;
endpackage

// File: rtl/hlp_latency_sel.sv
module hlp_latency_sel #(
  parameter int BASE_ONE  = 4,
  parameter int BASE_FEW  = 5,
  parameter int BASE_MANY = 6,
  parameter int EXTRA_W   = 3,
  parameter int IDX_W     = 4
) (
  input  logic [1:0]         size_i,
  input  logic [EXTRA_W-1:0] extra_i,
  output logic [IDX_W-1:0]   tap_o
);
  logic [IDX_W-1:0] base_v;

  always_comb begin
    unique case (size_i)
      2'b00:   base_v = IDX_W'(BASE_ONE);
      2'b01:   base_v = IDX_W'(BASE_FEW);
      default: base_v = IDX_W'(BASE_MANY);
    endcase
    // input register plus output register account for two cycles
    tap_o = base_v + IDX_W'(extra_i) - IDX_W'(2);
  end
endmodule

// File: rtl/hlp_delay_line.sv
module hlp_delay_line #(
  parameter int W     = 3,
  parameter int DEPTH = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     d_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic [W-1:0]     q_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else     stage[i] <= stage[i-1];
    end
  end

  always_comb begin
    if (sel_i > LAST) q_o = stage[DEPTH-1];
    else              q_o = stage[sel_i];
  end
endmodule

// File: rtl/hlp_flag_drive.sv
module hlp_flag_drive
  import hlp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_t slot_i,
  input  logic  last_dev_i,
  output logic  hit_o,
  output logic  valid_o,
  output logic  flag_oe_o,
  output logic  ack_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o     <= 1'b0;
      valid_o   <= 1'b0;
      flag_oe_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      ack_o <= slot_i.ack;
      if (slot_i.srch && slot_i.hit) begin
        hit_o     <= 1'b1;
        valid_o   <= 1'b1;
        flag_oe_o <= 1'b1;
      end else if (slot_i.srch) begin
        hit_o     <= 1'b0;
        valid_o   <= last_dev_i;
        flag_oe_o <= last_dev_i;
      end else begin
        hit_o     <= 1'b0;
        valid_o   <= 1'b0;
        flag_oe_o <= last_dev_i;
      end
    end
  end
endmodule

// File: rtl/hlp_bus_default.sv
module hlp_bus_default #(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last_bus_i,
  input  logic              local_i,
  input  logic [ADDR_W-1:0] sadr_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              ale_n_i,
  input  logic              oe_n_i,
  output logic [ADDR_W-1:0] sadr_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              ale_n_o,
  output logic              bus_oe_o,
  output logic              oe_n_o,
  output logic              oe_en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sadr_o   <= '1;
      ce_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      ale_n_o  <= 1'b1;
      bus_oe_o <= 1'b0;
      oe_n_o   <= 1'b1;
      oe_en_o  <= 1'b0;
    end else begin
      if (local_i) begin
        sadr_o  <= sadr_i;
        ce_n_o  <= ce_n_i;
        we_n_o  <= we_n_i;
        ale_n_o <= ale_n_i;
        oe_n_o  <= oe_n_i;
      end else begin
        sadr_o  <= '1;
        ce_n_o  <= 1'b1;
        we_n_o  <= 1'b1;
        ale_n_o <= 1'b1;
        oe_n_o  <= 1'b1;
      end
      bus_oe_o <= local_i | last_bus_i;
      oe_en_o  <= local_i | last_bus_i;
    end
  end
endmodule

// File: rtl/hit_latency_pipe.sv
module hit_latency_pipe
  import hlp_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BASE_ONE  = 4,
  parameter int BASE_FEW  = 5,
  parameter int BASE_MANY = 6,
  parameter int EXTRA_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_size_i,
  input  logic [EXTRA_W-1:0] cfg_extra_i,
  input  logic              cfg_last_dev_i,
  input  logic              cfg_last_bus_i,
  input  logic [1:0]        op_i,
  input  logic              hit_i,
  input  logic              ack_i,
  input  logic              local_drive_i,
  input  logic [ADDR_W-1:0] sadr_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              ale_n_i,
  input  logic              oe_n_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic              flag_oe_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] sadr_o,
  output logic              ce_n_o,
  output logic              we_n_o,
  output logic              ale_n_o,
  output logic              bus_oe_o,
  output logic              oe_n_o,
  output logic              oe_en_o
);
  localparam int MAX_LAT = BASE_MANY + (1 << EXTRA_W) - 1;
  localparam int DEPTH   = MAX_LAT - 1;
  localparam int IDX_W   = $clog2(DEPTH + 1);
  localparam int SLOT_W  = $bits(slot_t);

  slot_t            in_slot, tap_slot;
  logic [SLOT_W-1:0] tap_bits;
  logic [IDX_W-1:0]  tap_idx;

  always_comb begin
    in_slot.srch = (op_e'(op_i) == OP_SEARCH);
    in_slot.hit  = (op_e'(op_i) == OP_SEARCH) && hit_i;
    in_slot.ack  = (op_e'(op_i) == OP_READ) && ack_i;
  end

  hlp_latency_sel #(
    .BASE_ONE (BASE_ONE),
    .BASE_FEW (BASE_FEW),
    .BASE_MANY(BASE_MANY),
    .EXTRA_W  (EXTRA_W),
    .IDX_W    (IDX_W)
  ) u_sel (
    .size_i (cfg_size_i),
    .extra_i(cfg_extra_i),
    .tap_o  (tap_idx)
  );

  hlp_delay_line #(
    .W    (SLOT_W),
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_line (
    .clk  (clk),
    .rst  (rst),
    .d_i  (in_slot),
    .sel_i(tap_idx),
    .q_o  (tap_bits)
  );

  assign tap_slot = slot_t'(tap_bits);

  hlp_flag_drive u_flags (
    .clk       (clk),
    .rst       (rst),
    .slot_i    (tap_slot),
    .last_dev_i(cfg_last_dev_i),
    .hit_o     (hit_o),
    .valid_o   (valid_o),
    .flag_oe_o (flag_oe_o),
    .ack_o     (ack_o)
  );

  hlp_bus_default #(
    .ADDR_W(ADDR_W)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .last_bus_i(cfg_last_bus_i),
    .local_i   (local_drive_i),
    .sadr_i    (sadr_i),
    .ce_n_i    (ce_n_i),
    .we_n_i    (we_n_i),
    .ale_n_i   (ale_n_i),
    .oe_n_i    (oe_n_i),
    .sadr_o    (sadr_o),
    .ce_n_o    (ce_n_o),
    .we_n_o    (we_n_o),
    .ale_n_o   (ale_n_o),
    .bus_oe_o  (bus_oe_o),
    .oe_n_o    (oe_n_o),
    .oe_en_o   (oe_en_o)
  );
endmodule

// File: rtl/hlp_checker.sv
module hlp_checker #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_last_dev_i,
  input logic              cfg_last_bus_i,
  input logic              local_drive_i,
  input logic              hit_o,
  input logic              valid_o,
  input logic              flag_oe_o,
  input logic              ack_o,
  input logic [ADDR_W-1:0] sadr_o,
  input logic              ce_n_o,
  input logic              we_n_o,
  input logic              ale_n_o,
  input logic              bus_oe_o,
  input logic              oe_en_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flag_oe_o && !ack_o && !bus_oe_o && !oe_en_o && !hit_o));

  assert_hit_is_valid_R5: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (valid_o && flag_oe_o));

  assert_valid_driven_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> flag_oe_o);

  assert_silent_unless_hit_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && flag_oe_o && !$past(cfg_last_dev_i)) |-> hit_o);

  assert_bus_park_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bus_oe_o && !$past(local_drive_i)) |->
      (sadr_o == '1 && ce_n_o && we_n_o && ale_n_o));

  assert_oe_line_owner_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (oe_en_o == ($past(cfg_last_bus_i) || $past(local_drive_i))));
endmodule

bind hit_latency_pipe hlp_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_hit_latency_pipe.sv
module tb_hit_latency_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_size = 2'b00;
  logic [2:0] cfg_extra = 3'd0;
  logic cfg_last_dev = 1'b0, cfg_last_bus = 1'b0;
  logic [1:0] op = 2'b00;
  logic hit = 1'b0, ack = 1'b0, loc = 1'b0;
  logic [AW-1:0] sadr = '0;
  logic ce_n = 1'b1, we_n = 1'b1, ale_n = 1'b1, oe_n = 1'b1;
  logic hit_o, valid_o, flag_oe_o, ack_o, ce_n_o, we_n_o, ale_n_o, bus_oe_o, oe_n_o, oe_en_o;
  logic [AW-1:0] sadr_o;

  int n_chk = 0, n_fail = 0, k = 0;
  bit chk_en = 1'b0, done = 1'b0;
  logic [1:0] h_op [16];
  logic h_hit [16], h_ack [16];
  logic p_loc = 1'b0, p_ce = 1'b1, p_we = 1'b1, p_ale = 1'b1, p_oe = 1'b1;
  logic [AW-1:0] p_sadr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hit_latency_pipe dut (
    .clk(clk), .rst(rst), .cfg_size_i(cfg_size), .cfg_extra_i(cfg_extra),
    .cfg_last_dev_i(cfg_last_dev), .cfg_last_bus_i(cfg_last_bus),
    .op_i(op), .hit_i(hit), .ack_i(ack), .local_drive_i(loc),
    .sadr_i(sadr), .ce_n_i(ce_n), .we_n_i(we_n), .ale_n_i(ale_n), .oe_n_i(oe_n),
    .hit_o(hit_o), .valid_o(valid_o), .flag_oe_o(flag_oe_o), .ack_o(ack_o),
    .sadr_o(sadr_o), .ce_n_o(ce_n_o), .we_n_o(we_n_o), .ale_n_o(ale_n_o),
    .bus_oe_o(bus_oe_o), .oe_n_o(oe_n_o), .oe_en_o(oe_en_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, k);
    end
  endtask

  function automatic int lat();
    int b;
    b = (cfg_size == 2'b00) ? 4 : (cfg_size == 2'b01) ? 5 : 6;
    return b + int'(cfg_extra);
  endfunction

  // one cycle: check outputs due now, then drive the new inputs (at negedge)
  task automatic run_cycle(string req, logic [1:0] o, logic h, logic a);
    int L = lat();
    logic [1:0] eo = 2'b00;
    logic eh = 1'b0, ea = 1'b0;
    logic x_hit, x_val, x_oe, x_ack;
    if (k >= L) begin
      eo = h_op[(k-L)%16]; eh = h_hit[(k-L)%16]; ea = h_ack[(k-L)%16];
    end
    if (eo == 2'b01 && eh) begin x_hit = 1; x_val = 1; x_oe = 1; end
    else if (eo == 2'b01) begin x_hit = 0; x_val = cfg_last_dev; x_oe = cfg_last_dev; end
    else begin x_hit = 0; x_val = 0; x_oe = cfg_last_dev; end
    x_ack = (eo == 2'b10) && ea;
    if (chk_en) begin
      check(req, "hit_o", 32'(hit_o), 32'(x_hit));
      check(req, "valid_o", 32'(valid_o), 32'(x_val));
      check(req, "flag_oe_o", 32'(flag_oe_o), 32'(x_oe));
      check(req, "ack_o", 32'(ack_o), 32'(x_ack));
      // R10 R11 R12: bus follows last cycle's ownership
      check("R10 R11", "bus_oe_o", 32'(bus_oe_o), 32'(p_loc | cfg_last_bus));
      if (p_loc) begin
        check("R10", "sadr_o", 32'(sadr_o), 32'(p_sadr));
        check("R10", "ce/we/ale", 32'({ce_n_o, we_n_o, ale_n_o}), 32'({p_ce, p_we, p_ale}));
      end else if (cfg_last_bus) begin
        check("R11", "sadr_o", 32'(sadr_o), 32'({AW{1'b1}}));
        check("R11", "ce/we/ale", 32'({ce_n_o, we_n_o, ale_n_o}), 32'(3'b111));
      end
      check("R12", "oe_en_o", 32'(oe_en_o), 32'(p_loc | cfg_last_bus));
      check("R12", "oe_n_o", 32'(oe_n_o), 32'(p_loc ? p_oe : 1'b1));
    end
    op = o; hit = h; ack = a;
    h_op[k%16] = o; h_hit[k%16] = h; h_ack[k%16] = a;
    p_loc = loc; p_sadr = sadr; p_ce = ce_n; p_we = we_n; p_ale = ale_n; p_oe = oe_n;
    k++;
    @(negedge clk);
  endtask

  task automatic set_cfg(logic [1:0] s, logic [2:0] e, logic ld, logic lb);
    chk_en = 0;
    cfg_size = s; cfg_extra = e; cfg_last_dev = ld; cfg_last_bus = lb;
    for (int i = 0; i < 15; i++) run_cycle("-", 2'b00, 0, 0);
    chk_en = 1;
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) run_cycle(req, 2'b00, 0, 0);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1", "flags", 32'({hit_o, valid_o, flag_oe_o, ack_o}), 32'(0));
    check("R1", "bus enables", 32'({bus_oe_o, oe_en_o}), 32'(0));
    rst = 0;
    @(negedge clk);
    check("R1", "flags after release", 32'({hit_o, valid_o, flag_oe_o, ack_o}), 32'(0));
    check("R1", "bus after release", 32'({bus_oe_o, oe_en_o}), 32'(0));
  endtask

  task automatic t_base();
    set_cfg(2'b00, 3'd0, 0, 0);
    run_cycle("R2", 2'b01, 1, 0); idle("R2", 8);
    for (int s = 1; s < 4; s++) begin
      set_cfg(2'(s), 3'd0, 0, 0);
      run_cycle("R3", 2'b01, 1, 0); idle("R3", 9);
    end
  endtask

  task automatic t_extra();
    for (int e = 0; e < 8; e++) begin
      set_cfg(2'b01, 3'(e), 1, 0);
      run_cycle("R4", 2'b01, 1, 0); run_cycle("R4", 2'b10, 0, 1); idle("R4", 15);
    end
  endtask

  task automatic t_hit_miss();
    for (int d = 0; d < 2; d++) begin
      set_cfg(2'b00, 3'd2, 1'(d), 0);
      run_cycle("R5", 2'b01, 1, 0); idle("R7", 2);
      run_cycle("R6", 2'b01, 0, 0); idle("R7", 3);
      run_cycle("R5", 2'b01, 1, 0); run_cycle("R6", 2'b01, 0, 0);
      idle("R7", 10);
    end
  endtask

  task automatic t_ack();
    set_cfg(2'b10, 3'd1, 0, 0);
    run_cycle("R8", 2'b10, 0, 1); run_cycle("R8", 2'b00, 0, 1);
    run_cycle("R8", 2'b01, 0, 1); run_cycle("R8", 2'b11, 0, 1);
    run_cycle("R8", 2'b10, 0, 0); run_cycle("R8", 2'b10, 0, 1);
    idle("R8", 10);
  endtask

  task automatic t_stream();
    set_cfg(2'b01, 3'd3, 1, 0);
    for (int i = 0; i < 40; i++)
      run_cycle("R9", 2'((i * 7 + 1) % 4), 1'(((i * 5) >> 1) & 1), 1'(i % 3 != 0));
    idle("R9", 14);
  endtask

  task automatic t_bus();
    for (int b = 0; b < 2; b++) begin
      set_cfg(2'b00, 3'd0, 0, 1'(b));
      for (int i = 0; i < 12; i++) begin
        loc = 1'(i % 3 != 1);
        sadr = AW'(32'h15A3C7 ^ (i * 32'h1111));
        ce_n = 1'(i & 1); we_n = 1'((i >> 1) & 1); ale_n = 1'((i >> 2) & 1); oe_n = 1'(i % 3 == 0);
        run_cycle("R10", 2'b00, 0, 0);
      end
      loc = 0;
      idle("R11", 3);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_base();
    t_extra();
    t_hit_miss();
    t_ack();
    t_stream();
    t_bus();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule